// File: doc/BRIEF.md
# Descriptor Fetch and Done-Status Controller

This block runs one direction of a descriptor-driven DMA engine. Software programs a table base address and a local landing address into a small register bank. The table in host memory starts with a status area of 128 dwords, and the 32-byte descriptors follow it. Writing a descriptor index into the last-pointer register starts the engine. The engine then fetches descriptors one at a time from host memory, decodes the source address, destination address, dword length and ID of each, and hands them to an external data mover over a valid/ready link.

The mover reports each finished transfer by its descriptor ID, and the IDs may arrive in any order. An index that software wrote to the last-pointer register is marked for reporting. When the descriptor fetched at such an index finishes, the block writes a done dword into the status entry chosen by that descriptor's ID. Writing only the final index therefore gives a single report. Writing every index in turn gives one report per descriptor. Last-pointer writes that arrive while the engine is running extend the range of descriptors still to process.

Top module: `desc_dma_ctrl`

## Requirements
- R1: After reset, `busy`, `memReqValid`, `movValid` are low, and the engine starts at descriptor index 0.
- R2: The channel registers sit at `CHAN_BASE` plus these offsets: 0x00 table base bits 31:0, 0x04 table base bits 63:32, 0x08 local landing address bits 31:0, 0x0C landing address bits 63:32, 0x10 last pointer (index in bits 6:0). A write to any other address changes nothing.
- R3: The fetch of descriptor i is a read request (`memReqWrite`=0) to table base + 0x200 + 32*i, with `memReqLocal` equal to the landing address. The block never has more than one fetch outstanding.
- R4: Each fetch returns 8 response dwords. Dword 0 is source bits 31:0, dword 1 source bits 63:32, dword 2 destination bits 31:0, dword 3 destination bits 63:32, and dword 4 the control word (length in dwords at bits 17:0, ID at bits 24:18). The last three dwords are ignored. These fields appear on the mover outputs with `movValid`.
- R5: A last-pointer write of p causes descriptors from the next unprocessed index up to and including p to be handed over in order. Indices wrap modulo 128.
- R6: A last-pointer write that arrives while the engine is busy is not lost. It extends the range and marks its own index for reporting.
- R7: When a descriptor whose index was written to the last pointer completes, the block issues exactly one write (`memReqWrite`=1) of 0x0000_0001 to table base + 4*ID.
- R8: Done writes follow the completion ID given on `cplId`, whatever the order in which completions return.
- R9: A completion for a descriptor whose index was not marked for reporting produces no done write.
- R10: While `memReqValid` or `movValid` is high and not accepted, the request and its fields stay unchanged. `busy` falls once the range has been handed over and all requested done writes have been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register byte address |
| regWrData | input | 32 | Register write data |
| memReqValid | output | 1 | Host memory request valid |
| memReqReady | input | 1 | Host memory request accepted |
| memReqWrite | output | 1 | 1 = done write, 0 = descriptor read |
| memReqAddr | output | 64 | Host byte address |
| memReqWrData | output | 32 | Write data (done dword) |
| memReqLocal | output | 64 | Local landing address for read data |
| memRspValid | input | 1 | Read response dword valid |
| memRspData | input | 32 | Read response dword |
| movValid | output | 1 | Descriptor offered to the mover |
| movReady | input | 1 | Mover accepts the descriptor |
| movSrc | output | 64 | Source address |
| movDst | output | 64 | Destination address |
| movLen | output | LEN_W | Length in dwords |
| movId | output | IDX_W | Descriptor ID |
| cplValid | input | 1 | Mover completion strobe |
| cplId | input | IDX_W | ID of the completed descriptor |
| busy | output | 1 | Work or reporting still pending |

## Verification
The descriptor IDs differ from their table indices, so a design that put the status address on the index instead of the ID would write the wrong entries. The mover model finishes transfers in random order, so a design that reported in fetch order would write entries that no completion asked for. Last-pointer writes are issued in bursts while the engine runs, and some of them land in the same cycle that the targeted control dword is decoded. A design that dropped a queued write would stop early, and one that missed the same-cycle mark would lose a report. One range crosses index 127 to 0, which catches a design whose index does not wrap. Memory and mover back-pressure are random, so a design that let a request change while it was stalled would be caught.

// File: rtl/desc_dma_pkg.sv
package desc_dma_pkg;

  // Response dwords per descriptor fetch and the one holding the control word
  localparam int DESC_BEATS = 8;
  localparam int BEAT_W     = $clog2(DESC_BEATS);
  localparam int CTRL_BEAT  = 4;
  localparam logic [31:0] DONE_WORD = 32'h0000_0001;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_DATA,
    ST_HAND
  } fetchState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic              fetchValid;
    logic              doneValid;
    logic              capEn;
    logic [BEAT_W-1:0] capBeat;
    logic              handValid;
  } ctrlStrobe_t;

endpackage

// File: rtl/desc_dma_track.sv
module desc_dma_track #(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lpWr,
  input  logic [IDX_W-1:0] lpIdx,
  input  logic             decodeEn,
  input  logic [IDX_W-1:0] decodeIdx,
  input  logic [IDX_W-1:0] decodeId,
  input  logic             cplValid,
  input  logic [IDX_W-1:0] cplId,
  input  logic             doneTake,
  output logic             doneAny,
  output logic [IDX_W-1:0] doneSelId,
  output logic             pendAny
);
  localparam int NUM = 1 << IDX_W;

  logic [NUM-1:0] reportQ, reportN;  // indexed by descriptor index
  logic [NUM-1:0] pendQ, pendN;      // indexed by ID: waiting for completion
  logic [NUM-1:0] doneQ, doneN;      // indexed by ID: done write owed
  logic           decodeHit;

  always_comb begin
    reportN = reportQ;
    pendN   = pendQ;
    doneN   = doneQ;
    decodeHit = reportQ[decodeIdx] || (lpWr && (lpIdx == decodeIdx));
    if (lpWr) reportN[lpIdx] = 1'b1;
    if (decodeEn) begin
      reportN[decodeIdx] = 1'b0;
      if (decodeHit) pendN[decodeId] = 1'b1;
    end
    if (doneTake) doneN[doneSelId] = 1'b0;
    if (cplValid && pendQ[cplId]) begin
      pendN[cplId] = 1'b0;
      doneN[cplId] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reportQ <= '0;
      pendQ   <= '0;
      doneQ   <= '0;
    end else begin
      reportQ <= reportN;
      pendQ   <= pendN;
      doneQ   <= doneN;
    end
  end

  // Lowest owed ID goes first
  always_comb begin
    doneSelId = '0;
    for (int i = NUM - 1; i >= 0; i--) begin
      if (doneQ[i]) doneSelId = IDX_W'(i);
    end
  end

  assign doneAny = |doneQ;
  assign pendAny = |pendQ;

  // R8
  sel_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneAny |-> doneQ[doneSelId]);

  // R9
  no_stray_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cplValid && !pendQ[cplId] && !doneQ[cplId]) |=> !doneQ[$past(cplId)]);

endmodule

// File: rtl/desc_dma_fsm.sv
module desc_dma_fsm
  import desc_dma_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lpWr,
  input  logic [IDX_W-1:0] lpIdx,
  input  logic             memReqReady,
  input  logic             memRspValid,
  input  logic             movReady,
  input  logic             doneAny,
  input  logic [IDX_W-1:0] doneSelId,
  output ctrlStrobe_t      strobe,
  output logic [IDX_W-1:0] fetchIdx,
  output logic [IDX_W-1:0] doneId,
  output logic             doneTake,
  output logic             decodeEn,
  output logic             busyCore
);
  fetchState_e       state;
  logic [IDX_W-1:0]  nextIdx, lastPtr, doneIdQ;
  logic              workPend, doneBusy;
  logic [BEAT_W-1:0] beatCnt;
  logic              handFire, lastBeat;

  assign doneTake = doneAny && !doneBusy && (state != ST_REQ);
  assign handFire = (state == ST_HAND) && movReady;
  assign lastBeat = (beatCnt == BEAT_W'(DESC_BEATS - 1));

  always_comb begin
    strobe            = '0;
    strobe.fetchValid = (state == ST_REQ);
    strobe.doneValid  = doneBusy;
    strobe.capEn      = (state == ST_DATA) && memRspValid;
    strobe.capBeat    = beatCnt;
    strobe.handValid  = (state == ST_HAND);
  end

  assign decodeEn = strobe.capEn && (beatCnt == BEAT_W'(CTRL_BEAT));
  assign fetchIdx = nextIdx;
  assign doneId   = doneIdQ;
  assign busyCore = workPend || doneBusy || (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      nextIdx  <= '0;
      lastPtr  <= '0;
      workPend <= 1'b0;
      doneBusy <= 1'b0;
      doneIdQ  <= '0;
      beatCnt  <= '0;
    end else begin
      if (lpWr) begin
        lastPtr  <= lpIdx;
        workPend <= 1'b1;
      end else if (handFire && (nextIdx == lastPtr)) begin
        workPend <= 1'b0;
      end

      if (doneTake) begin
        doneBusy <= 1'b1;
        doneIdQ  <= doneSelId;
      end else if (doneBusy && memReqReady) begin
        doneBusy <= 1'b0;
      end

      unique case (state)
        ST_IDLE: if (workPend && !doneBusy && !doneAny) state <= ST_REQ;
        ST_REQ: if (memReqReady) begin
          state   <= ST_DATA;
          beatCnt <= '0;
        end
        ST_DATA: if (memRspValid) begin
          beatCnt <= beatCnt + 1'b1;
          if (lastBeat) state <= ST_HAND;
        end
        ST_HAND: if (movReady) begin
          nextIdx <= nextIdx + 1'b1;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10
  one_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.fetchValid && strobe.doneValid));

  // R3
  single_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fetchValid && memReqReady) |=> (state == ST_DATA));

endmodule

// File: rtl/desc_dma_dp.sv
module desc_dma_dp
  import desc_dma_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int CHAN_BASE = 0,
  parameter int IDX_W     = 7,
  parameter int LEN_W     = 18,
  parameter int ID_LSB    = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  input  ctrlStrobe_t       strobe,
  input  logic [IDX_W-1:0]  fetchIdx,
  input  logic [IDX_W-1:0]  doneId,
  input  logic [31:0]       memRspData,
  output logic              lpWr,
  output logic [IDX_W-1:0]  lpIdx,
  output logic [IDX_W-1:0]  rspId,
  output logic              memReqValid,
  output logic              memReqWrite,
  output logic [63:0]       memReqAddr,
  output logic [31:0]       memReqWrData,
  output logic [63:0]       memReqLocal,
  output logic [63:0]       movSrc,
  output logic [63:0]       movDst,
  output logic [LEN_W-1:0]  movLen,
  output logic [IDX_W-1:0]  movId
);
  localparam int STATUS_BYTES = (1 << IDX_W) * 4;
  localparam int DESC_SHIFT   = 5;  // 32-byte descriptors
  localparam logic [ADDR_W-1:0] A_BASE_LO = ADDR_W'(CHAN_BASE + 'h00);
  localparam logic [ADDR_W-1:0] A_BASE_HI = ADDR_W'(CHAN_BASE + 'h04);
  localparam logic [ADDR_W-1:0] A_FIFO_LO = ADDR_W'(CHAN_BASE + 'h08);
  localparam logic [ADDR_W-1:0] A_FIFO_HI = ADDR_W'(CHAN_BASE + 'h0C);
  localparam logic [ADDR_W-1:0] A_LAST    = ADDR_W'(CHAN_BASE + 'h10);

  logic [63:0]      tableBase, fifoAddr;
  logic [63:0]      fetchAddr, doneAddr;
  logic [31:0]      srcLo, srcHi, dstLo, dstHi;
  logic [LEN_W-1:0] lenQ;
  logic [IDX_W-1:0] idQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tableBase <= '0;
      fifoAddr  <= '0;
    end else if (regWrEn) begin
      unique case (regAddr)
        A_BASE_LO: tableBase[31:0]  <= regWrData;
        A_BASE_HI: tableBase[63:32] <= regWrData;
        A_FIFO_LO: fifoAddr[31:0]   <= regWrData;
        A_FIFO_HI: fifoAddr[63:32]  <= regWrData;
        default: ;
      endcase
    end
  end

  assign lpWr  = regWrEn && (regAddr == A_LAST);
  assign lpIdx = regWrData[IDX_W-1:0];
  assign rspId = memRspData[ID_LSB +: IDX_W];

  // Descriptor field capture by response beat
  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcLo <= '0; srcHi <= '0; dstLo <= '0; dstHi <= '0;
      lenQ  <= '0; idQ   <= '0;
    end else if (strobe.capEn) begin
      unique case (strobe.capBeat)
        BEAT_W'(0): srcLo <= memRspData;
        BEAT_W'(1): srcHi <= memRspData;
        BEAT_W'(2): dstLo <= memRspData;
        BEAT_W'(3): dstHi <= memRspData;
        BEAT_W'(CTRL_BEAT): begin
          lenQ <= memRspData[LEN_W-1:0];
          idQ  <= memRspData[ID_LSB +: IDX_W];
        end
        default: ;
      endcase
    end
  end

  assign movSrc = {srcHi, srcLo};
  assign movDst = {dstHi, dstLo};
  assign movLen = lenQ;
  assign movId  = idQ;

  assign fetchAddr = tableBase + 64'(STATUS_BYTES) + (64'(fetchIdx) << DESC_SHIFT);
  assign doneAddr  = tableBase + (64'(doneId) << 2);

  assign memReqValid  = strobe.fetchValid || strobe.doneValid;
  assign memReqWrite  = strobe.doneValid;
  assign memReqAddr   = strobe.doneValid ? doneAddr : fetchAddr;
  assign memReqWrData = strobe.doneValid ? DONE_WORD : 32'h0;
  assign memReqLocal  = strobe.doneValid ? 64'h0 : fifoAddr;

endmodule

// File: rtl/desc_dma_ctrl.sv
module desc_dma_ctrl
  import desc_dma_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int CHAN_BASE = 0,
  parameter int IDX_W     = 7,
  parameter int LEN_W     = 18,
  parameter int ID_LSB    = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic              memReqWrite,
  output logic [63:0]       memReqAddr,
  output logic [31:0]       memReqWrData,
  output logic [63:0]       memReqLocal,
  input  logic              memRspValid,
  input  logic [31:0]       memRspData,
  output logic              movValid,
  input  logic              movReady,
  output logic [63:0]       movSrc,
  output logic [63:0]       movDst,
  output logic [LEN_W-1:0]  movLen,
  output logic [IDX_W-1:0]  movId,
  input  logic              cplValid,
  input  logic [IDX_W-1:0]  cplId,
  output logic              busy
);
  ctrlStrobe_t      strobe;
  logic             lpWr, doneTake, decodeEn, busyCore, doneAny, pendAny;
  logic [IDX_W-1:0] lpIdx, rspId, fetchIdx, doneId, doneSelId;

  desc_dma_fsm #(.IDX_W(IDX_W)) uFsm (
    .clk, .rstN, .lpWr, .lpIdx, .memReqReady, .memRspValid, .movReady,
    .doneAny, .doneSelId, .strobe, .fetchIdx, .doneId, .doneTake,
    .decodeEn, .busyCore
  );

  desc_dma_dp #(
    .ADDR_W(ADDR_W), .CHAN_BASE(CHAN_BASE), .IDX_W(IDX_W),
    .LEN_W(LEN_W), .ID_LSB(ID_LSB)
  ) uDp (
    .clk, .rstN, .regWrEn, .regAddr, .regWrData, .strobe, .fetchIdx,
    .doneId, .memRspData, .lpWr, .lpIdx, .rspId, .memReqValid,
    .memReqWrite, .memReqAddr, .memReqWrData, .memReqLocal,
    .movSrc, .movDst, .movLen, .movId
  );

  desc_dma_track #(.IDX_W(IDX_W)) uTrack (
    .clk, .rstN, .lpWr, .lpIdx, .decodeEn, .decodeIdx(fetchIdx),
    .decodeId(rspId), .cplValid, .cplId, .doneTake, .doneAny,
    .doneSelId, .pendAny
  );

  assign movValid = strobe.handValid;
  assign busy     = busyCore || pendAny || doneAny;

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=>
      (memReqValid && $stable(memReqAddr) && $stable(memReqWrite)));

  // R4
  mov_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (movValid && !movReady) |=>
      (movValid && $stable(movSrc) && $stable(movDst) && $stable(movId)));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memReqValid && !movValid));

endmodule

// File: tb/desc_dma_ctrl_test.sv
module desc_dma_ctrl_test;
  localparam int ADDR_W = 12;
  localparam int IDX_W  = 7;
  localparam int LEN_W  = 18;
  localparam logic [63:0] TBASE = 64'h0000_0001_F000_0000;
  localparam logic [63:0] FIFO  = 64'h0000_0000_0100_0000;

  logic clk = 1'b0, rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic memReqValid, memReqWrite, memReqReady = 1'b0;
  logic [63:0] memReqAddr, memReqLocal;
  logic [31:0] memReqWrData;
  logic memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic movValid, movReady = 1'b0;
  logic [63:0] movSrc, movDst;
  logic [LEN_W-1:0] movLen;
  logic [IDX_W-1:0] movId;
  logic cplValid = 1'b0;
  logic [IDX_W-1:0] cplId = '0;
  logic busy;

  desc_dma_ctrl uut (
    .clk, .rstN, .regWrEn, .regAddr, .regWrData, .memReqValid, .memReqReady,
    .memReqWrite, .memReqAddr, .memReqWrData, .memReqLocal, .memRspValid,
    .memRspData, .movValid, .movReady, .movSrc, .movDst, .movLen, .movId,
    .cplValid, .cplId, .busy
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  bit modelOn = 0, done = 0;
  bit repBit[128], expDone[128], owed[128];
  int fetchExp = 0, movExp = 0, lastPtrB = 0, curIdx = 0, doneWrites = 0;
  bit inFlight = 0, prevStall = 0;
  logic [63:0] prevAddr;
  int rspQ[$], outQ[$];
  logic [43:0] wrQ[$];  // {addr, data}

  function automatic logic [6:0] idOf(int idx);
    return 7'(idx) ^ 7'h2A;
  endfunction
  function automatic logic [17:0] lenOf(int idx);
    return 18'(256 + idx * 3);
  endfunction
  function automatic logic [31:0] descWord(int idx, int beat);
    case (beat)
      0: return 32'h1000_0000 + 32'(idx) * 32'h100;
      1: return 32'(idx & 1);
      2: return 32'h5000_0000 + 32'(idx) * 32'h40;
      3: return 32'(idx >> 4);
      4: return {7'h55, idOf(idx), lenOf(idx)};
      default: return 32'hDEAD_0000 | 32'(beat);
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bus models: everything driven at the falling edge
  always @(negedge clk) begin
    if (modelOn) begin
      regWrEn = 1'b0;
      if (wrQ.size() != 0) begin
        logic [43:0] w;
        w = wrQ.pop_front();
        regWrEn = 1'b1; regAddr = w[43:32]; regWrData = w[31:0];
        if (w[43:32] == 12'h010) begin
          repBit[w[6:0]] = 1'b1;
          lastPtrB = int'(w[6:0]);
        end
      end
      memRspValid = 1'b0;
      if (rspQ.size() != 0 && ($urandom % 4) != 0) begin
        int b;
        b = rspQ.pop_front();
        memRspValid = 1'b1;
        memRspData = descWord(curIdx, b);
        if (b == 4) begin
          expDone[idOf(curIdx)] = repBit[curIdx];
          repBit[curIdx] = 1'b0;
        end
      end
      cplValid = 1'b0;
      if (outQ.size() != 0 && ($urandom % 3) == 0) begin
        int k, id;
        k = int'($urandom % outQ.size());
        id = outQ[k];
        outQ.delete(k);
        cplValid = 1'b1; cplId = 7'(id);
        if (expDone[id]) begin owed[id] = 1'b1; expDone[id] = 1'b0; end
      end
      if (prevStall) chk(memReqValid && memReqAddr == prevAddr, "R10 request held", memReqAddr, prevAddr);
      memReqReady = ($urandom % 3) != 0;
      prevStall = memReqValid && !memReqReady;
      prevAddr = memReqAddr;
      if (memReqValid && memReqReady) begin
        if (!memReqWrite) begin
          logic [63:0] ea;
          ea = TBASE + 64'h200 + 64'(fetchExp) * 32;
          chk(!inFlight, "R3 single fetch", 64'(inFlight), 0);
          chk(memReqAddr == ea, "R3 fetch address", memReqAddr, ea);
          chk(memReqLocal == FIFO, "R2 landing address", memReqLocal, FIFO);
          curIdx = fetchExp; fetchExp = (fetchExp + 1) % 128; inFlight = 1'b1;
          for (int b = 0; b < 8; b++) rspQ.push_back(b);
        end else begin
          logic [63:0] off;
          int id;
          off = memReqAddr - TBASE;
          id = int'(off[8:2]);
          doneWrites++;
          chk(off < 64'h200 && off[1:0] == 2'b00, "R7 status address", memReqAddr, TBASE);
          chk(memReqWrData == 32'h1, "R7 done dword", 64'(memReqWrData), 1);
          chk(owed[id], "R8 done id owed", 64'(id), 64'(id));
          owed[id] = 1'b0;
        end
      end
      movReady = ($urandom % 2) != 0;
      if (movValid && movReady) begin
        chk(movSrc == {descWord(movExp, 1), descWord(movExp, 0)}, "R4 source", movSrc, {descWord(movExp, 1), descWord(movExp, 0)});
        chk(movDst == {descWord(movExp, 3), descWord(movExp, 2)}, "R4 destination", movDst, {descWord(movExp, 3), descWord(movExp, 2)});
        chk(movLen == lenOf(movExp) && movId == idOf(movExp), "R4 length/id", {movLen, movId}, {lenOf(movExp), idOf(movExp)});
        outQ.push_back(int'(movId));
        movExp = (movExp + 1) % 128; inFlight = 1'b0;
      end
    end
  end

  task automatic lastPtr(input int p);
    wrQ.push_back({12'h010, 32'(p)});
  endtask

  task automatic waitIdle(input string req);
    int quiet = 0;
    while (quiet < 4) begin
      @(negedge clk);
      if (busy || wrQ.size() != 0 || outQ.size() != 0 || memRspValid) quiet = 0;
      else quiet++;
    end
    begin
      int owedCnt = 0, expCnt = 0;
      for (int i = 0; i < 128; i++) begin
        owedCnt += int'(owed[i]);
        expCnt += int'(expDone[i]);
      end
      chk(owedCnt == 0 && expCnt == 0, {req, " all reports written"}, 64'(owedCnt + expCnt), 0);
    end
    chk(movExp == (lastPtrB + 1) % 128, {req, " range end"}, 64'(movExp), 64'((lastPtrB + 1) % 128));
    chk(!busy && !memReqValid && !movValid, "R10 idle", 64'(busy), 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int base;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    chk(!busy && !memReqValid && !movValid, "R1 reset state", {busy, memReqValid, movValid}, 0);
    rstN = 1'b1;
    modelOn = 1;
    // R2: other addresses, including the neighbour channel, must not alter the table
    wrQ.push_back({12'h100, 32'hAAAA_0000});
    wrQ.push_back({12'h014, 32'hBBBB_0000});
    wrQ.push_back({12'h000, TBASE[31:0]});
    wrQ.push_back({12'h004, TBASE[63:32]});
    wrQ.push_back({12'h008, FIFO[31:0]});
    wrQ.push_back({12'h00C, FIFO[63:32]});
    wrQ.push_back({12'h10C, 32'hCCCC_0000});
    repeat (12) @(negedge clk);
    chk(!busy && !memReqValid, "R2 config alone starts nothing", 64'(busy), 0);
    chk(movExp == 0 && fetchExp == 0, "R1 starts at index 0", 64'(fetchExp), 0);

    // R5/R9: single write of index 2 reports only its own descriptor
    base = doneWrites;
    lastPtr(2);
    waitIdle("R5");
    chk(doneWrites - base == 1, "R9 single report", 64'(doneWrites - base), 1);

    // R6: queued writes while running, each reported
    base = doneWrites;
    lastPtr(3); lastPtr(4); lastPtr(5);
    waitIdle("R6");
    chk(doneWrites - base == 3, "R6 every queued report", 64'(doneWrites - base), 3);

    // R5: wrap through 127 to 1
    base = doneWrites;
    lastPtr(127);
    waitIdle("R5 up to 127");
    lastPtr(1);
    waitIdle("R5 wrap");
    chk(doneWrites - base == 2, "R7 wrap reports", 64'(doneWrites - base), 2);

    // Random ranges with bursts of extending writes
    for (int r = 0; r < 12; r++) begin
      int n, p;
      n = 1 + int'($urandom % 3);
      p = lastPtrB;
      for (int k = 0; k < n; k++) begin
        p = (p + 1 + int'($urandom % 5)) % 128;
        lastPtr(p);
        repeat (int'($urandom % 20)) @(negedge clk);
      end
      waitIdle("R8 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule